// File: doc/BRIEF.md
# Reorder Buffer with Precise Exceptions

This block keeps the in-flight instructions of an out-of-order core in program order. It is a circular buffer. Each instruction gets an entry when it is dispatched. The entry records the instruction's PC and its destination tag. Execution units later report completion against the entry index. A completion report carries the result value, an exception flag and a branch-mispredict flag. The result stays in the entry until the instruction retires.

Retirement happens only at the head, and up to two entries can retire in the same cycle. The rename unit receives the destination tag and the result of each retiring entry.

Mispredicts and exceptions are handled at different times:
- A mispredicted branch cuts off every younger entry in the cycle its completion arrives. The branch itself stays in the buffer and retires normally later.
- A faulting instruction waits until it reaches the head. It then raises a trap that carries its PC, and the buffer is emptied. Servicing the trap is left to the front end.

Top module: `rob_precise`

## Requirements
- R1: Out of reset, dispatches are accepted when `disp_valid` and `disp_ready` are both high. Each accepted dispatch takes the entry index shown on `disp_idx`. Indices advance by one per accepted dispatch, counting 0 to DEPTH-1 from reset and then wrapping to 0.
- R2: `disp_ready` is low whenever DEPTH entries are held. It is also low in any cycle that reports a flush or a trap. A dispatch offered in such a cycle is dropped.
- R3: The head entry retires on `cm_valid[0]` only when it is complete and its exception flag is clear. In that cycle it presents its destination on `cm_dest[DEST_W-1:0]` and its result on `cm_data[DATA_W-1:0]`.
- R4: The entry after the head retires on `cm_valid[1]`, using the upper fields of `cm_dest` and `cm_data`. This happens only when the head also retires in that cycle, and the second entry is complete and free of exceptions. A completed entry behind an incomplete head does not retire.
- R5: Several completion ports may each write a different entry in the same cycle. The result value written by a completion is the value later presented when that entry retires.
- R6: When the head entry is complete and flagged as excepting, `trap_valid` is high and `trap_pc` shows that entry's PC. Neither commit slot fires in that cycle. On the next cycle the buffer is empty, and the next dispatch takes the index the faulting entry had.
- R7: A completion with the mispredict flag set raises `flush_valid` in the same cycle, with `flush_idx` set to the branch's index. All younger entries are discarded. The branch entry is kept.
- R8: If several mispredicts arrive in one cycle, the one oldest in program order is reported and sets the flush point.
- R9: An excepting entry that is not at the head raises no trap. The older entries ahead of it still retire first.
- R10: A trap takes precedence over a mispredict in the same cycle. `flush_valid` stays low, and the buffer is emptied.
- R11: After reset the buffer is empty, `disp_ready` is high, `disp_idx` is 0, and no commit, flush or trap is signalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| disp_valid | input | 1 | Dispatch request |
| disp_pc | input | PC_W | PC of the dispatched instruction |
| disp_dest | input | DEST_W | Destination tag of the dispatched instruction |
| disp_ready | output | 1 | Dispatch accepted this cycle if requested |
| disp_idx | output | IW | Entry index given to the dispatched instruction |
| cmp_valid | input | NCMP | Per-port completion valid |
| cmp_idx | input | NCMP*IW | Per-port entry index being completed |
| cmp_exc | input | NCMP | Per-port exception flag |
| cmp_misp | input | NCMP | Per-port branch-mispredict flag |
| cmp_data | input | NCMP*DATA_W | Per-port result value |
| cm_valid | output | 2 | Commit strobes, bit 0 is the head |
| cm_dest | output | 2*DEST_W | Destinations of the committing entries |
| cm_data | output | 2*DATA_W | Results of the committing entries |
| flush_valid | output | 1 | Younger entries behind a mispredicted branch are discarded |
| flush_idx | output | IW | Index of the mispredicted branch |
| trap_valid | output | 1 | Excepting entry reached the head |
| trap_pc | output | PC_W | PC of the excepting entry |

## Verification
The bench aims at these cases:
- A completed second entry behind an incomplete head. A design that gates the two slots independently would retire it out of order.
- Two mispredicts in the same cycle. A design that picks by port number rather than by age would keep wrong-path entries.
- A trap that coincides with a mispredict. A design that lets the flush win would leave stale entries and misplace the next dispatch index.
- An excepting entry sitting behind completed older ones. A design that traps without waiting for the head would drop good results.
- Filling the buffer to its limit. A design that confuses full with empty would overwrite live entries.

// File: rtl/rob_precise.sv
module rob_precise #(
  parameter int DEPTH  = 6,
  parameter int PC_W   = 32,
  parameter int DEST_W = 6,
  parameter int DATA_W = 32,
  parameter int NCMP   = 3,
  localparam int IW    = (DEPTH > 2) ? $clog2(DEPTH) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   disp_valid,
  input  logic [PC_W-1:0]        disp_pc,
  input  logic [DEST_W-1:0]      disp_dest,
  output logic                   disp_ready,
  output logic [IW-1:0]          disp_idx,
  input  logic [NCMP-1:0]        cmp_valid,
  input  logic [NCMP*IW-1:0]     cmp_idx,
  input  logic [NCMP-1:0]        cmp_exc,
  input  logic [NCMP-1:0]        cmp_misp,
  input  logic [NCMP*DATA_W-1:0] cmp_data,
  output logic [1:0]             cm_valid,
  output logic [2*DEST_W-1:0]    cm_dest,
  output logic [2*DATA_W-1:0]    cm_data,
  output logic                   flush_valid,
  output logic [IW-1:0]          flush_idx,
  output logic                   trap_valid,
  output logic [PC_W-1:0]        trap_pc
);

  function automatic logic [IW:0] padd(input logic [IW:0] p, input int n);
    int s;
    s = int'(p[IW-1:0]) + n;
    if (s >= DEPTH) return {~p[IW], IW'(s - DEPTH)};
    return {p[IW], IW'(s)};
  endfunction

  function automatic int age_of(input logic [IW-1:0] i, input logic [IW-1:0] h);
    return (i >= h) ? int'(i) - int'(h) : int'(i) + DEPTH - int'(h);
  endfunction

  logic [IW:0]        head, tail, head1, fl_tail;
  logic [PC_W-1:0]    pc_q   [DEPTH];
  logic [DEST_W-1:0]  dest_q [DEPTH];
  logic [DATA_W-1:0]  data_q [DEPTH];
  logic [DEPTH-1:0]   done_q, exc_q;
  logic [IW-1:0]      h0, h1;
  logic               fl_any, acc;
  int                 occ, fl_age, ncm;

  assign h0    = head[IW-1:0];
  assign head1 = padd(head, 1);
  assign h1    = head1[IW-1:0];
  assign occ   = (head[IW] == tail[IW]) ? int'(tail[IW-1:0]) - int'(h0)
                                        : int'(tail[IW-1:0]) + DEPTH - int'(h0);

  assign trap_valid  = (occ > 0) && done_q[h0] && exc_q[h0];
  assign trap_pc     = pc_q[h0];
  assign cm_valid[0] = (occ > 0) && done_q[h0] && !exc_q[h0];
  assign cm_valid[1] = cm_valid[0] && (occ > 1) && done_q[h1] && !exc_q[h1];
  assign cm_dest     = {dest_q[h1], dest_q[h0]};
  assign cm_data     = {data_q[h1], data_q[h0]};
  assign ncm         = int'(cm_valid[0]) + int'(cm_valid[1]);

  always_comb begin
    fl_any    = 1'b0;
    fl_age    = DEPTH;
    flush_idx = '0;
    for (int p = 0; p < NCMP; p++) begin
      if (cmp_valid[p] && cmp_misp[p] &&
          age_of(cmp_idx[p*IW +: IW], h0) < occ &&
          age_of(cmp_idx[p*IW +: IW], h0) < fl_age) begin
        fl_any    = 1'b1;
        fl_age    = age_of(cmp_idx[p*IW +: IW], h0);
        flush_idx = cmp_idx[p*IW +: IW];
      end
    end
  end

  assign fl_tail     = padd(head, fl_age + 1);
  assign flush_valid = fl_any && !trap_valid;
  assign disp_ready  = (occ < DEPTH) && !flush_valid && !trap_valid;
  assign disp_idx    = tail[IW-1:0];
  assign acc         = disp_valid && disp_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      head   <= '0;
      tail   <= '0;
      done_q <= '0;
      exc_q  <= '0;
    end else begin
      for (int p = 0; p < NCMP; p++) begin
        if (cmp_valid[p]) begin
          done_q[cmp_idx[p*IW +: IW]] <= 1'b1;
          exc_q[cmp_idx[p*IW +: IW]]  <= cmp_exc[p];
          data_q[cmp_idx[p*IW +: IW]] <= cmp_data[p*DATA_W +: DATA_W];
        end
      end
      if (acc) begin
        pc_q[tail[IW-1:0]]   <= disp_pc;
        dest_q[tail[IW-1:0]] <= disp_dest;
        done_q[tail[IW-1:0]] <= 1'b0;
        exc_q[tail[IW-1:0]]  <= 1'b0;
      end
      if (trap_valid) begin
        tail <= head;
      end else begin
        head <= padd(head, ncm);
        if (flush_valid) tail <= fl_tail;
        else if (acc)    tail <= padd(tail, 1);
      end
    end
  end

  a_r2_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
    occ >= 0 && occ <= DEPTH);
  a_r1_dispatch_grows: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> occ == $past(occ) + 1 - $past(ncm));
  a_r4_pair_in_order: assert property (@(posedge clk) disable iff (!rst_n)
    cm_valid[1] |-> cm_valid[0]);
  a_r6_trap_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |-> !cm_valid[0]);
  a_r6_trap_empties: assert property (@(posedge clk) disable iff (!rst_n)
    trap_valid |=> occ == 0);
  a_r7_flush_keeps_branch: assert property (@(posedge clk) disable iff (!rst_n)
    flush_valid |=> occ >= 1 && occ <= $past(occ));

endmodule

// File: tb/tb_rob_precise.sv
module tb_rob_precise;
  localparam int D = 6, IW = 3, NC = 3, PW = 32, DW = 6, XW = 32;

  logic clk = 1'b0, rst_n = 1'b0;
  always #4 clk = ~clk;

  logic disp_valid;
  logic [PW-1:0] disp_pc;
  logic [DW-1:0] disp_dest;
  logic disp_ready, flush_valid, trap_valid;
  logic [IW-1:0] disp_idx, flush_idx;
  logic [NC-1:0] cmp_valid, cmp_exc, cmp_misp;
  logic [NC*IW-1:0] cmp_idx;
  logic [NC*XW-1:0] cmp_data;
  logic [1:0] cm_valid;
  logic [2*DW-1:0] cm_dest;
  logic [2*XW-1:0] cm_data;
  logic [PW-1:0] trap_pc;

  rob_precise dut (.clk, .rst_n, .disp_valid, .disp_pc, .disp_dest, .disp_ready, .disp_idx,
    .cmp_valid, .cmp_idx, .cmp_exc, .cmp_misp, .cmp_data, .cm_valid, .cm_dest, .cm_data,
    .flush_valid, .flush_idx, .trap_valid, .trap_pc);

  int tests = 0, fails = 0;
  int mh = 0, mocc = 0;
  logic [PW-1:0] m_pc [D];
  logic [DW-1:0] m_dest [D];
  logic [XW-1:0] m_data [D];
  bit m_done [D];
  bit m_exc [D];

  task automatic chk(string req, bit ok, longint act, longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic int ix(int a);
    return (mh + a) % D;
  endfunction

  task automatic clear_in();
    disp_valid = 0; disp_pc = '0; disp_dest = '0;
    cmp_valid = '0; cmp_exc = '0; cmp_misp = '0; cmp_idx = '0; cmp_data = '0;
  endtask

  task automatic set_cmp(int p, int age, bit e, bit m);
    cmp_valid[p] = 1'b1;
    cmp_idx[p*IW +: IW] = IW'(ix(age));
    cmp_exc[p] = e;
    cmp_misp[p] = m;
    cmp_data[p*XW +: XW] = $urandom;
  endtask

  task automatic rand_in(int p_disp, int p_exc, int p_misp);
    bit used [D];
    clear_in();
    for (int i = 0; i < D; i++) used[i] = 0;
    disp_valid = ($urandom % 100) < p_disp;
    disp_pc = $urandom;
    disp_dest = DW'($urandom);
    for (int p = 0; p < NC; p++) begin
      if (mocc > 0 && ($urandom % 3) == 0) begin
        int a = int'($urandom % mocc);
        if (!m_done[ix(a)] && !used[ix(a)]) begin
          used[ix(a)] = 1;
          set_cmp(p, a, ($urandom % 100) < p_exc, ($urandom % 100) < p_misp);
        end
      end
    end
  endtask

  task automatic step();
    bit e_trap, e_c0, e_c1, e_fl, e_rdy, acc;
    int h1, fl_age, fl_ix, ncm;
    #1;
    h1 = (mh + 1) % D;
    e_trap = mocc > 0 && m_done[mh] && m_exc[mh];
    e_c0 = mocc > 0 && m_done[mh] && !m_exc[mh];
    e_c1 = e_c0 && mocc > 1 && m_done[h1] && !m_exc[h1];
    fl_age = D; fl_ix = 0;
    for (int p = 0; p < NC; p++) begin
      int i = int'(cmp_idx[p*IW +: IW]);
      int a = (i - mh + D) % D;
      if (cmp_valid[p] && cmp_misp[p] && a < mocc && a < fl_age) begin
        fl_age = a; fl_ix = i;
      end
    end
    e_fl = fl_age < D && !e_trap;
    e_rdy = mocc < D && !e_fl && !e_trap;
    chk("R3/R4 commit strobes", cm_valid == {e_c1, e_c0}, cm_valid, {e_c1, e_c0});
    if (e_c0) begin
      chk("R3 head dest", cm_dest[DW-1:0] == m_dest[mh], cm_dest[DW-1:0], m_dest[mh]);
      chk("R5 head data", cm_data[XW-1:0] == m_data[mh], cm_data[XW-1:0], m_data[mh]);
    end
    if (e_c1) begin
      chk("R4 second dest", cm_dest[2*DW-1:DW] == m_dest[h1], cm_dest[2*DW-1:DW], m_dest[h1]);
      chk("R5 second data", cm_data[2*XW-1:XW] == m_data[h1], cm_data[2*XW-1:XW], m_data[h1]);
    end
    chk("R6 R9 trap", trap_valid == e_trap, trap_valid, e_trap);
    if (e_trap) chk("R6 trap pc", trap_pc == m_pc[mh], trap_pc, m_pc[mh]);
    chk("R7 R10 flush", flush_valid == e_fl, flush_valid, e_fl);
    if (e_fl) chk("R8 flush idx", int'(flush_idx) == fl_ix, flush_idx, fl_ix);
    chk("R2 ready", disp_ready == e_rdy, disp_ready, e_rdy);
    if (e_rdy) chk("R1 disp idx", int'(disp_idx) == (mh + mocc) % D, disp_idx, (mh + mocc) % D);
    acc = disp_valid && e_rdy;
    for (int p = 0; p < NC; p++) if (cmp_valid[p]) begin
      int i = int'(cmp_idx[p*IW +: IW]);
      m_done[i] = 1; m_exc[i] = cmp_exc[p]; m_data[i] = cmp_data[p*XW +: XW];
    end
    if (acc) begin
      int t = (mh + mocc) % D;
      m_pc[t] = disp_pc; m_dest[t] = disp_dest; m_done[t] = 0; m_exc[t] = 0;
    end
    ncm = int'(e_c0) + int'(e_c1);
    if (e_trap) mocc = 0;
    else begin
      mh = (mh + ncm) % D;
      if (e_fl) mocc = fl_age + 1 - ncm;
      else mocc = mocc - ncm + int'(acc);
    end
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < D; i++) begin m_done[i] = 0; m_exc[i] = 0; end
    clear_in();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R11 reset ready", disp_ready == 1'b1, disp_ready, 1);
    chk("R11 reset idle", {cm_valid, flush_valid, trap_valid} == 4'b0, {cm_valid, flush_valid, trap_valid}, 0);
    chk("R11 reset idx", disp_idx == '0, disp_idx, 0);
    @(negedge clk);
    for (int k = 0; k < D + 1; k++) begin
      clear_in(); disp_valid = 1; disp_pc = 32'h1000 + 32'(k * 4); disp_dest = DW'(k + 1);
      step();
    end
    #1 chk("R2 full stall", disp_ready == 1'b0, disp_ready, 0);
    clear_in(); set_cmp(0, 1, 0, 0); step();
    clear_in(); step();
    clear_in(); set_cmp(1, 0, 0, 0); step();
    clear_in(); step();
    clear_in(); set_cmp(0, 3, 0, 1); set_cmp(2, 1, 0, 1); step();
    for (int k = 0; k < 3; k++) begin
      clear_in(); disp_valid = 1; disp_pc = 32'h2000 + 32'(k * 4); disp_dest = DW'(k + 9);
      step();
    end
    clear_in(); set_cmp(0, 0, 1, 0); step();
    clear_in(); disp_valid = 1; set_cmp(1, 2, 0, 1); step();
    clear_in(); disp_valid = 1; disp_pc = 32'h3000; step();
    for (int k = 0; k < 1500; k++) begin rand_in(60, 4, 6); step(); end
    for (int k = 0; k < 1500; k++) begin rand_in(90, 1, 2); step(); end
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule